// File: doc/BRIEF.md
# Rice Residual Decoder Engine

The engine turns a packed stream of Rice-coded prediction residuals into signed 32-bit integers. A processor arms it with a one-cycle start pulse. It then hands over seven 32-bit arguments through a small two-phase register slave port. After the last argument the engine works on its own. It fetches 32-bit words from a word-addressed memory through a master port and reads each word from the most significant bit down. A residual may straddle a word boundary.

Each residual is decoded in three steps. The engine first counts zero bits up to a terminating one; that count is the quotient. It then reads a fixed number of remainder bits. Finally it unfolds the sign. The engine stops when the requested number of samples is complete, when the input words run out, or when a quotient is too large. It then writes three status words through the same master port and raises a level done flag. The status tells software how far the input was consumed, so a later call can resume in the middle of a word.

Top module: `rice_residual_engine`

## Requirements
- R1: An argument transfer is one cycle with `reg_sel_i`=1 and `reg_en_i`=0, followed by one cycle with both at 1; the word on `reg_wdata_i` is captured in the second cycle. After a start, seven transfers are taken in this order: source address, return-buffer address, Rice parameter k (bits 4:0), words available, samples requested, starting bit offset (bits 5:0, values above 32 treated as 32), status address.
- R2: Every memory transfer is one cycle with `mem_sel_o`=1 and `mem_en_o`=0, followed by one cycle with both at 1, and the address stays stable across the two. A read takes `mem_rdata_i` in the second cycle. Input words are read from source+0, source+1, ... in turn. A new word is read only when a bit is needed and all 32 bits of the current word are used. Bits are taken MSB first.
- R3: The quotient q is the number of 0 bits before the first 1 bit. Then k bits are read MSB first as the remainder r, and the folded value is v = (q << k) | r. When k = 0 no remainder bit is read, and a quotient may run across word boundaries.
- R4: v unfolds to v/2 when v is even and to -(v+1)/2 when v is odd. Sample i is written to return address + i.
- R5: Bits of the first word start at the given offset. A word read later starts at bit 0. An offset of 32 means the first word is read but none of its bits are used.
- R6: Decoding ends when the number of written samples equals the request, including a request of 0, which reads no word. It also ends when a bit is needed and the number of words read equals the words available; a sample cut short this way is not written.
- R7: At the end, three words are written: status+0 = samples written, status+1 = words read, status+2 = {bit 31 error flag, bits 5:0 = bits used in the last word read (the offset if none)}. `done_o` then rises, `busy_o` is low, and `done_o` stays high until the next start.
- R8: If (q << k) does not fit in 32 bits, that sample is not written, the error flag is set and decoding ends.
- R9: While `busy_o` is high, `start_i` and transfers on the register port have no effect. The memory port is idle whenever `busy_o` is low.
- R10: After reset `busy_o`, `done_o` and `mem_sel_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start pulse |
| reg_sel_i | input | 1 | Register port select |
| reg_en_i | input | 1 | Register port enable (second phase) |
| reg_wdata_i | input | 32 | Argument word |
| mem_sel_o | output | 1 | Memory transfer select |
| mem_en_o | output | 1 | Memory transfer enable (second phase) |
| mem_write_o | output | 1 | 1 for a write transfer |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid in the enable cycle |
| busy_o | output | 1 | Engine is taking arguments or decoding |
| done_o | output | 1 | Status written, held until next start |

## Verification
A memory transfer is due three cycles after the engine decides it needs one: a request cycle, the select cycle and the enable cycle. `done_o` rises in the cycle after the enable cycle of the third status write. The bench samples every transfer on the falling clock edge inside its enable cycle. There it compares direction, address and write data with the next entry of a transaction list, which a behavioural bit-level model computes from the memory contents and the arguments. After `done_o` is seen, the bench checks that the list is empty and checks the flags, so each result is judged exactly in the cycle it appears on the port.

// File: rtl/rice_pkg.sv
package rice_pkg;

    localparam int WORD_W    = 32;
    localparam int PARAM_W   = 5;
    localparam int POS_W     = 6;
    localparam int NUM_ARGS  = 7;
    localparam int ARG_IDX_W = $clog2(NUM_ARGS);
    localparam int STAT_WORDS = 3;

    // argument slots, in the order software sends them
    localparam int ARG_SRC   = 0;
    localparam int ARG_RET   = 1;
    localparam int ARG_K     = 2;
    localparam int ARG_AVAIL = 3;
    localparam int ARG_REQ   = 4;
    localparam int ARG_OFS   = 5;
    localparam int ARG_STAT  = 6;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_SETUP,
        CAP_ACCESS
    } cap_state_t;

    typedef enum logic [1:0] {
        MST_IDLE,
        MST_SETUP,
        MST_ACCESS
    } mst_state_t;

    typedef enum logic [3:0] {
        ENG_IDLE,
        ENG_ARGS,
        ENG_NEXT,
        ENG_UNARY,
        ENG_REM,
        ENG_RD_REQ,
        ENG_RD_WAIT,
        ENG_SIGN,
        ENG_WR_REQ,
        ENG_WR_WAIT,
        ENG_STAT_REQ,
        ENG_STAT_WAIT,
        ENG_DONE
    } eng_state_t;

    typedef struct packed {
        logic             err;
        logic [POS_W-1:0] pos;
    } tail_info_t;

    // zig-zag unfold: even -> non-negative, odd -> negative
    function automatic logic [WORD_W-1:0] unfold_sign(input logic [WORD_W-1:0] v);
        return (v >> 1) ^ {WORD_W{v[0]}};
    endfunction

    function automatic logic [WORD_W-1:0] pack_tail(input tail_info_t t);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1]  = t.err;
        w[POS_W-1:0] = t.pos;
        return w;
    endfunction

endpackage

// File: rtl/rice_arg_capture.sv
module rice_arg_capture
    import rice_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              arm_i,
    input  logic                              reg_sel_i,
    input  logic                              reg_en_i,
    input  logic [WORD_W-1:0]                 reg_wdata_i,
    output logic [NUM_ARGS-1:0][WORD_W-1:0]   args_o,
    output logic                              loaded_o
);

    cap_state_t           cstate;
    logic [ARG_IDX_W-1:0] idx;
    logic                 active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cstate   <= CAP_IDLE;
            idx      <= '0;
            active   <= 1'b0;
            loaded_o <= 1'b0;
            args_o   <= '0;
        end else begin
            loaded_o <= 1'b0;
            if (arm_i) begin
                active <= 1'b1;
                idx    <= '0;
                cstate <= CAP_IDLE;
            end else if (active) begin
                case (cstate)
                    CAP_IDLE: begin
                        if (reg_sel_i && !reg_en_i) cstate <= CAP_SETUP;
                    end
                    CAP_SETUP: begin
                        if (reg_sel_i && reg_en_i) begin
                            args_o[idx] <= reg_wdata_i;
                            cstate      <= CAP_ACCESS;
                        end
                    end
                    CAP_ACCESS: begin
                        cstate <= CAP_IDLE;
                        if (idx == ARG_IDX_W'(NUM_ARGS - 1)) begin
                            active   <= 1'b0;
                            loaded_o <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    default: cstate <= CAP_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rice_mem_master.sv
module rice_mem_master
    import rice_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              ack_o,
    output logic              mem_sel_o,
    output logic              mem_en_o,
    output logic              mem_write_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o
);

    mst_state_t        mstate;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mstate  <= MST_IDLE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            case (mstate)
                MST_IDLE: begin
                    if (req_i) begin
                        wr_q    <= wr_i;
                        addr_q  <= addr_i;
                        wdata_q <= wdata_i;
                        mstate  <= MST_SETUP;
                    end
                end
                MST_SETUP:  mstate <= MST_ACCESS;
                MST_ACCESS: mstate <= MST_IDLE;
                default:    mstate <= MST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_sel_o   = (mstate != MST_IDLE);
        mem_en_o    = (mstate == MST_ACCESS);
        mem_write_o = mem_sel_o && wr_q;
        mem_addr_o  = addr_q;
        mem_wdata_o = wdata_q;
        ack_o       = (mstate == MST_ACCESS);
    end

endmodule

// File: rtl/rice_value_build.sv
module rice_value_build
    import rice_pkg::*;
(
    input  logic [WORD_W-1:0]  quot_i,
    input  logic [PARAM_W-1:0] k_i,
    input  logic [WORD_W-1:0]  rem_i,
    output logic [WORD_W-1:0]  residual_o,
    output logic               ovf_o
);

    logic [2*WORD_W-1:0] wide;
    logic [WORD_W-1:0]   folded;

    always_comb begin
        wide       = {{WORD_W{1'b0}}, quot_i} << k_i;
        ovf_o      = |wide[2*WORD_W-1:WORD_W];
        folded     = wide[WORD_W-1:0] | rem_i;
        residual_o = unfold_sign(folded);
    end

endmodule

// File: rtl/rice_residual_engine.sv
module rice_residual_engine
    import rice_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              reg_sel_i,
    input  logic              reg_en_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic              mem_sel_o,
    output logic              mem_en_o,
    output logic              mem_write_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o
);

    localparam logic [POS_W-1:0] POS_FULL  = POS_W'(WORD_W);
    localparam int               STAT_IDX_W = $clog2(STAT_WORDS);

    eng_state_t                      state;
    logic [NUM_ARGS-1:0][WORD_W-1:0] args;
    logic                            loaded;
    logic                            arm;

    logic [ADDR_W-1:0]  src_a, ret_a, stat_a;
    logic [PARAM_W-1:0] k;
    logic [CNT_W-1:0]   avail, req, nsamp, used;
    logic [POS_W-1:0]   pos;
    logic               have_word;
    logic               err;
    logic [WORD_W-1:0]  cur_word;
    logic [WORD_W-1:0]  quot, rem;
    logic [PARAM_W-1:0] rem_cnt;
    logic               back_to_rem;
    logic [STAT_IDX_W-1:0] stat_idx;
    logic [WORD_W-1:0]  res_q;

    logic               need_word;
    logic               bit_now;
    logic [WORD_W-1:0]  residual;
    logic               ovf;

    logic               m_req, m_wr, m_ack;
    logic [ADDR_W-1:0]  m_addr;
    logic [WORD_W-1:0]  m_wdata;
    tail_info_t         tail;
    logic [POS_W-1:0]   ofs_arg;

    logic               unused_arg_bits;

    assign arm = start_i && (state == ENG_IDLE || state == ENG_DONE);

    rice_arg_capture u_args (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm),
        .reg_sel_i   (reg_sel_i),
        .reg_en_i    (reg_en_i),
        .reg_wdata_i (reg_wdata_i),
        .args_o      (args),
        .loaded_o    (loaded)
    );

    rice_mem_master #(.ADDR_W(ADDR_W)) u_mst (
        .clk         (clk),
        .rst         (rst),
        .req_i       (m_req),
        .wr_i        (m_wr),
        .addr_i      (m_addr),
        .wdata_i     (m_wdata),
        .ack_o       (m_ack),
        .mem_sel_o   (mem_sel_o),
        .mem_en_o    (mem_en_o),
        .mem_write_o (mem_write_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o)
    );

    rice_value_build u_val (
        .quot_i     (quot),
        .k_i        (k),
        .rem_i      (rem),
        .residual_o (residual),
        .ovf_o      (ovf)
    );

    // bit supply
    always_comb begin
        need_word = !have_word || (pos == POS_FULL);
        bit_now   = cur_word[~pos[4:0]];
        ofs_arg   = (args[ARG_OFS][WORD_W-1:POS_W] != '0 || args[ARG_OFS][POS_W-1:0] > POS_FULL)
                    ? POS_FULL : args[ARG_OFS][POS_W-1:0];
        tail.err  = err;
        tail.pos  = pos;
    end

    // memory request mux
    always_comb begin
        m_req   = 1'b0;
        m_wr    = 1'b0;
        m_addr  = '0;
        m_wdata = '0;
        case (state)
            ENG_RD_REQ: begin
                m_req  = 1'b1;
                m_addr = src_a + ADDR_W'(used);
            end
            ENG_WR_REQ: begin
                m_req   = 1'b1;
                m_wr    = 1'b1;
                m_addr  = ret_a + ADDR_W'(nsamp);
                m_wdata = res_q;
            end
            ENG_STAT_REQ: begin
                m_req  = 1'b1;
                m_wr   = 1'b1;
                m_addr = stat_a + ADDR_W'(stat_idx);
                case (stat_idx)
                    STAT_IDX_W'(0): m_wdata = WORD_W'(nsamp);
                    STAT_IDX_W'(1): m_wdata = WORD_W'(used);
                    default:        m_wdata = pack_tail(tail);
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ENG_IDLE;
            src_a       <= '0;
            ret_a       <= '0;
            stat_a      <= '0;
            k           <= '0;
            avail       <= '0;
            req         <= '0;
            nsamp       <= '0;
            used        <= '0;
            pos         <= '0;
            have_word   <= 1'b0;
            err         <= 1'b0;
            cur_word    <= '0;
            quot        <= '0;
            rem         <= '0;
            rem_cnt     <= '0;
            back_to_rem <= 1'b0;
            stat_idx    <= '0;
            res_q       <= '0;
        end else begin
            case (state)
                ENG_IDLE, ENG_DONE: begin
                    if (start_i) state <= ENG_ARGS;
                end
                ENG_ARGS: begin
                    if (loaded) begin
                        src_a     <= args[ARG_SRC][ADDR_W-1:0];
                        ret_a     <= args[ARG_RET][ADDR_W-1:0];
                        stat_a    <= args[ARG_STAT][ADDR_W-1:0];
                        k         <= args[ARG_K][PARAM_W-1:0];
                        avail     <= args[ARG_AVAIL][CNT_W-1:0];
                        req       <= args[ARG_REQ][CNT_W-1:0];
                        pos       <= ofs_arg;
                        nsamp     <= '0;
                        used      <= '0;
                        have_word <= 1'b0;
                        err       <= 1'b0;
                        stat_idx  <= '0;
                        state     <= ENG_NEXT;
                    end
                end
                ENG_NEXT: begin
                    quot    <= '0;
                    rem     <= '0;
                    rem_cnt <= '0;
                    state   <= (nsamp == req) ? ENG_STAT_REQ : ENG_UNARY;
                end
                ENG_UNARY: begin
                    if (need_word) begin
                        back_to_rem <= 1'b0;
                        state       <= (used == avail) ? ENG_STAT_REQ : ENG_RD_REQ;
                    end else begin
                        pos <= pos + 1'b1;
                        if (bit_now) begin
                            state <= (k == '0) ? ENG_SIGN : ENG_REM;
                        end else begin
                            quot <= quot + 1'b1;
                        end
                    end
                end
                ENG_REM: begin
                    if (need_word) begin
                        back_to_rem <= 1'b1;
                        state       <= (used == avail) ? ENG_STAT_REQ : ENG_RD_REQ;
                    end else begin
                        pos     <= pos + 1'b1;
                        rem     <= {rem[WORD_W-2:0], bit_now};
                        rem_cnt <= rem_cnt + 1'b1;
                        if (rem_cnt == k - PARAM_W'(1)) state <= ENG_SIGN;
                    end
                end
                ENG_RD_REQ: state <= ENG_RD_WAIT;
                ENG_RD_WAIT: begin
                    if (m_ack) begin
                        cur_word  <= mem_rdata_i;
                        used      <= used + 1'b1;
                        have_word <= 1'b1;
                        if (have_word) pos <= '0;
                        state <= back_to_rem ? ENG_REM : ENG_UNARY;
                    end
                end
                ENG_SIGN: begin
                    if (ovf) begin
                        err   <= 1'b1;
                        state <= ENG_STAT_REQ;
                    end else begin
                        res_q <= residual;
                        state <= ENG_WR_REQ;
                    end
                end
                ENG_WR_REQ: state <= ENG_WR_WAIT;
                ENG_WR_WAIT: begin
                    if (m_ack) begin
                        nsamp <= nsamp + 1'b1;
                        state <= ENG_NEXT;
                    end
                end
                ENG_STAT_REQ: state <= ENG_STAT_WAIT;
                ENG_STAT_WAIT: begin
                    if (m_ack) begin
                        if (stat_idx == STAT_IDX_W'(STAT_WORDS - 1)) begin
                            state <= ENG_DONE;
                        end else begin
                            stat_idx <= stat_idx + 1'b1;
                            state    <= ENG_STAT_REQ;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign busy_o = (state != ENG_IDLE) && (state != ENG_DONE);
    assign done_o = (state == ENG_DONE);

    assign unused_arg_bits = ^{args[ARG_SRC], args[ARG_RET], args[ARG_STAT],
                               args[ARG_K], args[ARG_AVAIL], args[ARG_REQ]};

endmodule

// File: rtl/rice_residual_engine_chk.sv
module rice_residual_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              mem_sel_o,
    input logic              mem_en_o,
    input logic              mem_write_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              busy_o,
    input logic              done_o
);

    // R2: enable phase only after a select-only phase
    p_access_after_setup_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_sel_o && mem_en_o) |-> $past(mem_sel_o && !mem_en_o));

    // R2: select-only phase is always followed by the enable phase
    p_setup_then_access_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_sel_o && !mem_en_o) |=> (mem_sel_o && mem_en_o));

    // R2: address held across the two phases
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_sel_o && mem_en_o) |-> $stable(mem_addr_o));

    // R2: write flag only inside a transfer
    p_write_in_xfer_r2: assert property (@(posedge clk) disable iff (rst)
        mem_write_o |-> mem_sel_o);

    // R7: done and busy never together
    p_done_excl_busy_r7: assert property (@(posedge clk) disable iff (rst)
        !(done_o && busy_o));

    // R7: done held until a new start
    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    // R9: memory port quiet when not busy
    p_quiet_bus_r9: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_sel_o);

endmodule

bind rice_residual_engine rice_residual_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .mem_sel_o   (mem_sel_o),
    .mem_en_o    (mem_en_o),
    .mem_write_o (mem_write_o),
    .mem_addr_o  (mem_addr_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/rice_residual_engine_tb_top.sv
`timescale 1ns/1ps
module rice_residual_engine_tb_top;

    localparam int ADDR_W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic        reg_en_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic        mem_sel_o, mem_en_o, mem_write_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i;
    logic        busy_o, done_o;

    always #2.5 clk = ~clk;

    logic [31:0] mem [0:1023];
    assign mem_rdata_i = mem[mem_addr_o[9:0]];

    rice_residual_engine #(.ADDR_W(ADDR_W), .CNT_W(16)) dut_i (
        .clk (clk), .rst (rst), .start_i (start_i),
        .reg_sel_i (reg_sel_i), .reg_en_i (reg_en_i), .reg_wdata_i (reg_wdata_i),
        .mem_sel_o (mem_sel_o), .mem_en_o (mem_en_o), .mem_write_o (mem_write_o),
        .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o), .mem_rdata_i (mem_rdata_i),
        .busy_o (busy_o), .done_o (done_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    string cur_tag = "R10";

    typedef struct {
        bit          wr;
        int unsigned addr;
        logic [31:0] data;
    } txn_t;
    txn_t exp_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // transaction monitor, sampled mid-cycle in the enable phase
    always @(negedge clk) begin
        if (!rst && mem_sel_o && mem_en_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected transfer addr", 64'(mem_addr_o), 64'hFFFF);
            end else begin
                txn_t e;
                e = exp_q.pop_front();
                check(mem_write_o == e.wr, cur_tag, "transfer direction", 64'(mem_write_o), 64'(e.wr));
                check(int'(mem_addr_o) == e.addr, cur_tag, "transfer address", 64'(mem_addr_o), 64'(e.addr));
                if (e.wr) begin
                    check(mem_wdata_o == e.data, cur_tag, "write data", 64'(mem_wdata_o), 64'(e.data));
                end
            end
            if (mem_write_o) mem[mem_addr_o[9:0]] = mem_wdata_o;
        end
    end

    // behavioural reference model state
    int unsigned m_src, m_avail, m_used, m_pos;
    bit          m_have;
    logic [31:0] m_word;

    task automatic get_bit(output bit b, output bit ok);
        ok = 1'b1;
        b  = 1'b0;
        while (!m_have || m_pos == 32) begin
            if (m_used == m_avail) begin
                ok = 1'b0;
                return;
            end
            exp_q.push_back('{1'b0, m_src + m_used, 32'h0});
            m_word = mem[(m_src + m_used) & 1023];
            if (m_have) m_pos = 0;
            m_have = 1'b1;
            m_used++;
        end
        b = m_word[31 - m_pos];
        m_pos++;
    endtask

    task automatic build_expect(input int unsigned src, ret, k, avail, req, off, stat);
        int unsigned n, q;
        bit err, ok, b;
        logic [31:0] r, val;
        logic [63:0] v;
        n = 0; err = 0; ok = 1;
        m_src = src; m_avail = avail; m_used = 0; m_have = 0;
        m_pos = (off > 32) ? 32 : off;
        while (n < req) begin
            q = 0; r = '0;
            forever begin
                get_bit(b, ok);
                if (!ok || b) break;
                q++;
            end
            if (!ok) break;
            for (int i = 0; i < int'(k); i++) begin
                get_bit(b, ok);
                if (!ok) break;
                r = {r[30:0], b};
            end
            if (!ok) break;
            v = (64'(q) << k) | 64'(r);
            if (v[63:32] != 0) begin
                err = 1'b1;
                break;
            end
            val = (v[31:0] >> 1) ^ {32{v[0]}};
            exp_q.push_back('{1'b1, ret + n, val});
            n++;
        end
        exp_q.push_back('{1'b1, stat,     32'(n)});
        exp_q.push_back('{1'b1, stat + 1, 32'(m_used)});
        exp_q.push_back('{1'b1, stat + 2, {err, 25'b0, 6'(m_pos)}});
    endtask

    task automatic send_arg(input logic [31:0] w);
        reg_sel_i = 1'b1; reg_en_i = 1'b0; reg_wdata_i = w;
        @(negedge clk);
        reg_en_i = 1'b1;
        @(negedge clk);
        reg_sel_i = 1'b0; reg_en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_now();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic run_case(input string tag, input int unsigned src, ret, k, avail,
                            req, off, stat, input bit disturb);
        bit seen;
        cur_tag = tag;
        build_expect(src, ret, k, avail, req, off, stat);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        send_arg(src);   send_arg(ret);  send_arg(k);
        send_arg(avail); send_arg(req);  send_arg(off);
        send_arg(stat);
        seen = 1'b0;
        for (int cyc = 0; cyc < 50000; cyc++) begin
            @(negedge clk);
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            if (disturb && cyc == 40 && busy_o) begin
                // R9: start pulse and a stray argument transfer mid-decode
                start_i = 1'b1; reg_sel_i = 1'b1; reg_en_i = 1'b0; reg_wdata_i = 32'hDEAD_BEEF;
                @(negedge clk);
                start_i = 1'b0; reg_en_i = 1'b1;
                @(negedge clk);
                reg_sel_i = 1'b0; reg_en_i = 1'b0;
            end
        end
        if (!seen) begin
            check(1'b0, tag, "watchdog: done never rose", 64'(busy_o), 64'h1);
            finish_now();
        end
        check(exp_q.size() == 0, tag, "R7 transfers left over", 64'(exp_q.size()), 64'h0);
        exp_q.delete();
        check(busy_o == 1'b0, tag, "R7 busy after done", 64'(busy_o), 64'h0);
        @(negedge clk);
        check(done_o == 1'b1, tag, "R7 done held", 64'(done_o), 64'h1);
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "WDOG", "global watchdog expired", 64'h0, 64'h1);
        finish_now();
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i] = (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 7) ^ 32'h5A5A_0F0F;
        end
        mem[21] = 32'h0000_0000;       // unary run across two boundaries
        mem[22] = 32'h0000_0001;
        mem[60] = 32'h2000_0000;       // q=2 then k=31 -> overflow
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b0,    "R10", "busy after reset", 64'(busy_o), 64'h0);
        check(done_o == 1'b0,    "R10", "done after reset", 64'(done_o), 64'h0);
        check(mem_sel_o == 1'b0, "R10", "select after reset", 64'(mem_sel_o), 64'h0);

        run_case("R1/R2/R3/R4/R7 k=4",        0,   512, 4,  8,  12,  0,  900, 1'b0);
        run_case("R3 k=0 zero-param path",    8,   540, 0,  4,  20,  3,  903, 1'b0);
        run_case("R5 resume offset 27",       20,  570, 6,  6,  10,  27, 906, 1'b0);
        run_case("R6 input exhausted",        40,  600, 9,  2,  200, 5,  909, 1'b0);
        run_case("R6 zero samples requested", 50,  640, 3,  4,  0,   11, 912, 1'b0);
        run_case("R8 quotient overflow",      60,  700, 31, 2,  4,   0,  915, 1'b0);
        run_case("R5 offset 32 skips word",   70,  720, 3,  3,  5,  32,  918, 1'b0);
        run_case("R9 start and args ignored", 80,  760, 2,  16, 60,  1,  921, 1'b1);
        run_case("R4/R7 long k=12",           100, 830, 12, 10, 18,  9,  924, 1'b0);

        finish_now();
    end

endmodule